// File: doc/BRIEF.md
# Pipeline Operand Bypass and Load Interlock Control

This block is the hazard control for a five-stage in-order integer pipeline (fetch, decode, execute, memory, writeback). It is purely combinational. It looks at the register numbers that the decode and execute stages read. It also looks at the destination numbers, write enables and load/store flags held in the three downstream pipeline registers. From these it chooses where each operand comes from: the register-file read, the EX/MEM result, or the MEM/WB result.

The block drives four operand selects: the two ALU inputs, the branch zero-test operand in execute, and the write-data input of data memory for a store in the memory stage. It also raises one interlock signal when a load is followed directly by an instruction that needs the loaded value as an ALU or branch operand. While that signal is high, the surrounding pipeline holds the PC and the IF/ID register and loads a no-op into ID/EX. This gives exactly one bubble.

A store whose data register was just loaded does not stall. That value is bypassed into the data-memory input one stage later. Registers are read in decode and written in writeback, so write-after-read and write-after-write ordering needs no logic here. The block has no streaming data path, so all of its pins are plain control levels.

Top module: `bypass_interlock`

## Requirements
- R1: The A select (source `ex_rs`, used when `ex_rs_used`=1) and the B select (source `ex_rt`, used when `ex_rt_used`=1) are 2'd1 (EX/MEM result) when their source equals `exm_rd`, `exm_we`=1 and `exm_load`=0.
- R2: An ALU select is 2'd2 (MEM/WB result) when its source equals `mwb_rd` with `mwb_we`=1, and EX/MEM does not write that same register.
- R3: When EX/MEM and MEM/WB both write an operand's register, EX/MEM wins. If EX/MEM is a load writing that register, the select is 2'd0 (register file) and MEM/WB is still not chosen.
- R4: Register 0 is never a bypass match and never causes an interlock.
- R5: A stage whose write enable is 0 is never a bypass source.
- R6: `load_use_stall`=1 exactly when ID/EX holds a load (`idex_load`=1, `idex_we`=1) with a nonzero `idex_rd` that equals `id_rs` (when `id_rs_used`=1) or `id_rt` (when `id_rt_alu`=1).
- R7: A store whose data register (`id_rt` with `id_rt_alu`=0) matches a preceding load does not stall. When the store is in the memory stage (`exm_store`=1), `st_data_sel`=1 (MEM/WB value) if MEM/WB writes `exm_rt`; otherwise it is 0 (value carried in EX/MEM).
- R8: The zero-test select `fwd_z_sel` follows the R1–R5 rules on `ex_rs` only when `ex_branch`=1, and is 2'd0 otherwise.
- R9: An ALU select whose operand is marked unused is 2'd0 regardless of register matches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs | input | AW | First source register of the decode-stage instruction |
| id_rt | input | AW | Second source register of the decode-stage instruction |
| id_rs_used | input | 1 | Decode instruction reads id_rs in execute |
| id_rt_alu | input | 1 | Decode instruction uses id_rt as an ALU operand (not as store data) |
| idex_rd | input | AW | Destination held in ID/EX |
| idex_we | input | 1 | ID/EX instruction writes a register |
| idex_load | input | 1 | ID/EX instruction is a load |
| ex_rs | input | AW | First source of the execute-stage instruction |
| ex_rt | input | AW | Second source of the execute-stage instruction |
| ex_rs_used | input | 1 | Execute instruction reads ex_rs as ALU input A |
| ex_rt_used | input | 1 | Execute instruction reads ex_rt (ALU input B or store data) |
| ex_branch | input | 1 | Execute instruction is a branch testing ex_rs against zero |
| exm_rd | input | AW | Destination held in EX/MEM |
| exm_we | input | 1 | EX/MEM instruction writes a register |
| exm_load | input | 1 | EX/MEM instruction is a load |
| exm_store | input | 1 | EX/MEM instruction is a store |
| exm_rt | input | AW | Data register of the store in EX/MEM |
| mwb_rd | input | AW | Destination held in MEM/WB |
| mwb_we | input | 1 | MEM/WB instruction writes a register |
| fwd_a_sel | output | 2 | ALU input A source: 0 register file, 1 EX/MEM, 2 MEM/WB |
| fwd_b_sel | output | 2 | ALU input B source, same encoding |
| fwd_z_sel | output | 2 | Branch zero-test operand source, same encoding |
| st_data_sel | output | 1 | Data-memory write data: 0 EX/MEM value, 1 MEM/WB value |
| load_use_stall | output | 1 | Hold PC and IF/ID, insert a bubble into ID/EX |

## Verification
The bench builds the block with the default register-number width of 5. That width reaches both register 0, which must never match, and register 31, the top of the field, so the equality compares are exercised across every bit. Directed scenarios place the same register in several stages at once to cover the priority order. The interlock is checked in both positions of a load: in ID/EX, where it must stall, and one stage later in EX/MEM, where the bubble has already been taken and no stall may occur.

// File: rtl/byp_pkg.sv
package byp_pkg;
  typedef enum logic [1:0] {
    SRC_RF  = 2'd0,
    SRC_EXM = 2'd1,
    SRC_MWB = 2'd2
  } fwd_src_e;

  localparam int N_EX_OPERANDS = 3;
  localparam int OP_A = 0;
  localparam int OP_B = 1;
  localparam int OP_Z = 2;
endpackage

// File: rtl/byp_operand_sel.sv
module byp_operand_sel
  import byp_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] src,
  input  logic          used,
  input  logic [AW-1:0] exm_rd,
  input  logic          exm_we,
  input  logic          exm_load,
  input  logic [AW-1:0] mwb_rd,
  input  logic          mwb_we,
  output fwd_src_e      sel
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic live;
  logic hit_exm;
  logic hit_mwb;

  // Register 0 is hard-wired and never needs a bypass.
  assign live    = used && (src != ZERO_REG);
  assign hit_exm = live && exm_we && (exm_rd == src);
  assign hit_mwb = live && mwb_we && (mwb_rd == src);

  always_comb begin
    sel = SRC_RF;
    if (hit_exm) begin
      // The younger producer owns the register. A load there has no
      // value yet; the interlock keeps this case from being consumed.
      sel = exm_load ? SRC_RF : SRC_EXM;
    end else if (hit_mwb) begin
      sel = SRC_MWB;
    end
  end
endmodule

// File: rtl/byp_store_sel.sv
module byp_store_sel #(
  parameter int AW = 5
) (
  input  logic          exm_store,
  input  logic [AW-1:0] exm_rt,
  input  logic [AW-1:0] mwb_rd,
  input  logic          mwb_we,
  output logic          st_data_sel
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  assign st_data_sel = exm_store && mwb_we &&
                       (exm_rt != ZERO_REG) && (mwb_rd == exm_rt);
endmodule

// File: rtl/byp_load_interlock.sv
module byp_load_interlock #(
  parameter int AW = 5
) (
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic          id_rs_used,
  input  logic          id_rt_alu,
  input  logic [AW-1:0] idex_rd,
  input  logic          idex_we,
  input  logic          idex_load,
  output logic          stall
);
  localparam logic [AW-1:0] ZERO_REG = '0;

  logic load_pending;
  logic rs_dep;
  logic rt_dep;

  assign load_pending = idex_load && idex_we && (idex_rd != ZERO_REG);
  assign rs_dep       = id_rs_used && (id_rs == idex_rd);
  // Store data is excluded: it is bypassed at the memory stage instead.
  assign rt_dep       = id_rt_alu && (id_rt == idex_rd);
  assign stall        = load_pending && (rs_dep || rt_dep);
endmodule

// File: rtl/bypass_interlock.sv
module bypass_interlock
  import byp_pkg::*;
#(
  parameter int AW = 5
) (
  input  logic [AW-1:0] id_rs,
  input  logic [AW-1:0] id_rt,
  input  logic          id_rs_used,
  input  logic          id_rt_alu,
  input  logic [AW-1:0] idex_rd,
  input  logic          idex_we,
  input  logic          idex_load,
  input  logic [AW-1:0] ex_rs,
  input  logic [AW-1:0] ex_rt,
  input  logic          ex_rs_used,
  input  logic          ex_rt_used,
  input  logic          ex_branch,
  input  logic [AW-1:0] exm_rd,
  input  logic          exm_we,
  input  logic          exm_load,
  input  logic          exm_store,
  input  logic [AW-1:0] exm_rt,
  input  logic [AW-1:0] mwb_rd,
  input  logic          mwb_we,
  output logic [1:0]    fwd_a_sel,
  output logic [1:0]    fwd_b_sel,
  output logic [1:0]    fwd_z_sel,
  output logic          st_data_sel,
  output logic          load_use_stall
);
  logic [AW-1:0] op_src  [N_EX_OPERANDS];
  logic          op_used [N_EX_OPERANDS];
  fwd_src_e      op_sel  [N_EX_OPERANDS];

  assign op_src[OP_A]  = ex_rs;
  assign op_used[OP_A] = ex_rs_used;
  assign op_src[OP_B]  = ex_rt;
  assign op_used[OP_B] = ex_rt_used;
  assign op_src[OP_Z]  = ex_rs;
  assign op_used[OP_Z] = ex_branch;

  for (genvar g = 0; g < N_EX_OPERANDS; g++) begin : g_op
    byp_operand_sel #(.AW(AW)) u_sel (
      .src      (op_src[g]),
      .used     (op_used[g]),
      .exm_rd   (exm_rd),
      .exm_we   (exm_we),
      .exm_load (exm_load),
      .mwb_rd   (mwb_rd),
      .mwb_we   (mwb_we),
      .sel      (op_sel[g])
    );
  end

  assign fwd_a_sel = op_sel[OP_A];
  assign fwd_b_sel = op_sel[OP_B];
  assign fwd_z_sel = op_sel[OP_Z];

  byp_store_sel #(.AW(AW)) u_st (
    .exm_store   (exm_store),
    .exm_rt      (exm_rt),
    .mwb_rd      (mwb_rd),
    .mwb_we      (mwb_we),
    .st_data_sel (st_data_sel)
  );

  byp_load_interlock #(.AW(AW)) u_lock (
    .id_rs      (id_rs),
    .id_rt      (id_rt),
    .id_rs_used (id_rs_used),
    .id_rt_alu  (id_rt_alu),
    .idex_rd    (idex_rd),
    .idex_we    (idex_we),
    .idex_load  (idex_load),
    .stall      (load_use_stall)
  );
endmodule

// File: rtl/byp_checker.sv
module byp_checker #(
  parameter int AW = 5
) (
  input logic [AW-1:0] ex_rs,
  input logic          ex_rs_used,
  input logic          ex_branch,
  input logic [AW-1:0] exm_rd,
  input logic          exm_we,
  input logic          exm_load,
  input logic          mwb_we,
  input logic [AW-1:0] idex_rd,
  input logic          idex_we,
  input logic          idex_load,
  input logic [1:0]    fwd_a_sel,
  input logic [1:0]    fwd_b_sel,
  input logic [1:0]    fwd_z_sel,
  input logic          st_data_sel,
  input logic          load_use_stall
);
  always_comb begin
    if (ex_rs_used && exm_we && !exm_load && exm_rd == ex_rs && ex_rs != '0)
      AST_EXM_WINS: assert (fwd_a_sel == 2'd1); // R3
    if (ex_rs == '0)
      AST_ZERO_REG_LOCAL: assert (fwd_a_sel == 2'd0 && fwd_z_sel == 2'd0); // R4
    if (!exm_we && !mwb_we)
      AST_NO_WRITER: assert (fwd_a_sel == 2'd0 && fwd_b_sel == 2'd0 &&
                             fwd_z_sel == 2'd0 && !st_data_sel); // R5
    if (load_use_stall)
      AST_STALL_HAS_LOAD: assert (idex_load && idex_we && idex_rd != '0); // R6
    if (!ex_branch)
      AST_ZTEST_IDLE: assert (fwd_z_sel == 2'd0); // R8
    AST_SEL_CODE: assert (fwd_a_sel != 2'd3 && fwd_b_sel != 2'd3); // R2
  end
endmodule

bind bypass_interlock byp_checker #(.AW(AW)) u_chk (
  .ex_rs          (ex_rs),
  .ex_rs_used     (ex_rs_used),
  .ex_branch      (ex_branch),
  .exm_rd         (exm_rd),
  .exm_we         (exm_we),
  .exm_load       (exm_load),
  .mwb_we         (mwb_we),
  .idex_rd        (idex_rd),
  .idex_we        (idex_we),
  .idex_load      (idex_load),
  .fwd_a_sel      (fwd_a_sel),
  .fwd_b_sel      (fwd_b_sel),
  .fwd_z_sel      (fwd_z_sel),
  .st_data_sel    (st_data_sel),
  .load_use_stall (load_use_stall)
);

// File: tb/sim_bypass_interlock.sv
module sim_bypass_interlock;
  localparam int AW = 5;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [AW-1:0] id_rs = '0, id_rt = '0, idex_rd = '0, ex_rs = '0, ex_rt = '0;
  logic [AW-1:0] exm_rd = '0, exm_rt = '0, mwb_rd = '0;
  logic id_rs_used = 0, id_rt_alu = 0, idex_we = 0, idex_load = 0;
  logic ex_rs_used = 0, ex_rt_used = 0, ex_branch = 0;
  logic exm_we = 0, exm_load = 0, exm_store = 0, mwb_we = 0;
  logic [1:0] fwd_a_sel, fwd_b_sel, fwd_z_sel;
  logic st_data_sel, load_use_stall;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 0;

  bypass_interlock #(.AW(AW)) u0 (
    .id_rs(id_rs), .id_rt(id_rt), .id_rs_used(id_rs_used), .id_rt_alu(id_rt_alu),
    .idex_rd(idex_rd), .idex_we(idex_we), .idex_load(idex_load),
    .ex_rs(ex_rs), .ex_rt(ex_rt), .ex_rs_used(ex_rs_used), .ex_rt_used(ex_rt_used),
    .ex_branch(ex_branch), .exm_rd(exm_rd), .exm_we(exm_we), .exm_load(exm_load),
    .exm_store(exm_store), .exm_rt(exm_rt), .mwb_rd(mwb_rd), .mwb_we(mwb_we),
    .fwd_a_sel(fwd_a_sel), .fwd_b_sel(fwd_b_sel), .fwd_z_sel(fwd_z_sel),
    .st_data_sel(st_data_sel), .load_use_stall(load_use_stall)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic idle();
    @(negedge clk);
    id_rs = '0; id_rt = '0; idex_rd = '0; ex_rs = '0; ex_rt = '0;
    exm_rd = '0; exm_rt = '0; mwb_rd = '0;
    id_rs_used = 0; id_rt_alu = 0; idex_we = 0; idex_load = 0;
    ex_rs_used = 0; ex_rt_used = 0; ex_branch = 0;
    exm_we = 0; exm_load = 0; exm_store = 0; mwb_we = 0;
  endtask

  task automatic settle();
    #1;
  endtask

  task automatic t_reset();
    idle(); settle();
    chk("R5", "idle a_sel", fwd_a_sel, 0);
    chk("R5", "idle b_sel", fwd_b_sel, 0);
    chk("R6", "idle stall", load_use_stall, 0);
    chk("R7", "idle st_sel", st_data_sel, 0);
  endtask

  task automatic t_exm_fwd();
    idle();
    ex_rs = 5'd7; ex_rs_used = 1; ex_rt = 5'd31; ex_rt_used = 1;
    exm_rd = 5'd7; exm_we = 1; settle();
    chk("R1", "a from EX/MEM", fwd_a_sel, 1);
    chk("R1", "b unmatched", fwd_b_sel, 0);
    exm_rd = 5'd31; settle();
    chk("R1", "b from EX/MEM r31", fwd_b_sel, 1);
    chk("R1", "a now unmatched", fwd_a_sel, 0);
  endtask

  task automatic t_mwb_fwd();
    idle();
    ex_rs = 5'd4; ex_rs_used = 1; ex_rt = 5'd4; ex_rt_used = 1;
    mwb_rd = 5'd4; mwb_we = 1; exm_rd = 5'd9; exm_we = 1; settle();
    chk("R2", "a from MEM/WB", fwd_a_sel, 2);
    chk("R2", "b from MEM/WB", fwd_b_sel, 2);
  endtask

  task automatic t_priority();
    idle();
    ex_rs = 5'd12; ex_rs_used = 1;
    exm_rd = 5'd12; exm_we = 1; mwb_rd = 5'd12; mwb_we = 1; settle();
    chk("R3", "younger wins", fwd_a_sel, 1);
    exm_load = 1; settle();
    chk("R3", "load in EX/MEM hides older", fwd_a_sel, 0);
  endtask

  task automatic t_reg0();
    idle();
    ex_rs = '0; ex_rs_used = 1; ex_rt = '0; ex_rt_used = 1; ex_branch = 1;
    exm_rd = '0; exm_we = 1; mwb_rd = '0; mwb_we = 1; settle();
    chk("R4", "a r0", fwd_a_sel, 0);
    chk("R4", "b r0", fwd_b_sel, 0);
    chk("R4", "z r0", fwd_z_sel, 0);
    id_rs = '0; id_rs_used = 1; idex_rd = '0; idex_we = 1; idex_load = 1; settle();
    chk("R4", "stall r0", load_use_stall, 0);
    exm_store = 1; exm_rt = '0; settle();
    chk("R4", "store r0", st_data_sel, 0);
  endtask

  task automatic t_write_en();
    idle();
    ex_rs = 5'd3; ex_rs_used = 1; exm_rd = 5'd3; exm_we = 0;
    mwb_rd = 5'd3; mwb_we = 1; settle();
    chk("R5", "exm we low falls to mwb", fwd_a_sel, 2);
    mwb_we = 0; settle();
    chk("R5", "both we low", fwd_a_sel, 0);
    idex_rd = 5'd3; idex_load = 1; idex_we = 0; id_rs = 5'd3; id_rs_used = 1; settle();
    chk("R5", "load without we no stall", load_use_stall, 0);
  endtask

  task automatic t_load_use();
    idle();
    idex_rd = 5'd8; idex_we = 1; idex_load = 1;
    id_rs = 5'd8; id_rs_used = 1; settle();
    chk("R6", "rs dep stalls", load_use_stall, 1);
    id_rs = 5'd2; id_rt = 5'd8; id_rt_alu = 1; settle();
    chk("R6", "rt alu dep stalls", load_use_stall, 1);
    idex_load = 0; settle();
    chk("R6", "alu producer no stall", load_use_stall, 0);
    // after the bubble the load sits in EX/MEM: no second stall
    idle();
    id_rs = 5'd8; id_rs_used = 1; exm_rd = 5'd8; exm_we = 1; exm_load = 1; settle();
    chk("R6", "one bubble only", load_use_stall, 0);
  endtask

  task automatic t_store_after_load();
    idle();
    idex_rd = 5'd6; idex_we = 1; idex_load = 1;
    id_rs = 5'd1; id_rs_used = 1; id_rt = 5'd6; id_rt_alu = 0; settle();
    chk("R7", "store data dep no stall", load_use_stall, 0);
    idle();
    exm_store = 1; exm_rt = 5'd6; mwb_rd = 5'd6; mwb_we = 1; settle();
    chk("R7", "store data from MEM/WB", st_data_sel, 1);
    mwb_rd = 5'd5; settle();
    chk("R7", "store data no match", st_data_sel, 0);
    mwb_rd = 5'd6; exm_store = 0; settle();
    chk("R7", "not a store", st_data_sel, 0);
  endtask

  task automatic t_branch();
    idle();
    ex_rs = 5'd10; ex_branch = 1; exm_rd = 5'd10; exm_we = 1; settle();
    chk("R8", "z from EX/MEM", fwd_z_sel, 1);
    exm_rd = 5'd11; mwb_rd = 5'd10; mwb_we = 1; settle();
    chk("R8", "z from MEM/WB", fwd_z_sel, 2);
    ex_branch = 0; settle();
    chk("R8", "z idle without branch", fwd_z_sel, 0);
  endtask

  task automatic t_unused();
    idle();
    ex_rs = 5'd14; ex_rt = 5'd14; exm_rd = 5'd14; exm_we = 1;
    mwb_rd = 5'd14; mwb_we = 1; settle();
    chk("R9", "a unused", fwd_a_sel, 0);
    chk("R9", "b unused", fwd_b_sel, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    if (!finished) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_reset();
    t_exm_fwd();
    t_mwb_fwd();
    t_priority();
    t_reg0();
    t_write_en();
    t_load_use();
    t_store_after_load();
    t_branch();
    t_unused();
    finished = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule